// File: doc/BRIEF.md
# Address-Mark Wake-Up Receiver

This block is the receive front end of an asynchronous serial link that several processors share. Each character on the wire has a low start bit, eight data bits sent least significant bit first, a ninth bit that marks the character as an address, and a high stop bit. The receiver samples the line on a free-running 16x oversample enable. It decides each bit at the centre of its bit time, and it presents every finished character as a one-cycle valid pulse with the data byte and the address flag.

Software can put the receiver to sleep with a one-cycle strobe, so it skips characters meant for other stations. While asleep it still frames every character but drops each one. Idle line time does not wake it. The receiver wakes itself when a character has its ninth bit set. The sleep flag drops as soon as that bit is decided, which comes before the stop bit is sampled, so the waking address character is the first one delivered.

The framer is a five-state machine. IDLE waits for a low level on an oversample tick and moves to START. START re-samples the line at half a bit time. If the line is still low it moves to DATA. If the line has gone high it returns to IDLE (false start). DATA takes eight centre samples and then moves to ADDR. ADDR takes one centre sample, raises the wake request when that sample is 1, and moves to STOP. STOP takes one centre sample, ends the character and returns to IDLE.

Top module: `amw_rx`

## Requirements
- R1: After reset, `rwu_o`, `rx_valid`, `rx_addr` and all bits of `rx_data` are 0.
- R2: While awake, each character produces exactly one `rx_valid` pulse one clock wide. In the same cycle, `rx_data[i]` holds the (i+1)-th data bit after the start bit and `rx_addr` holds the ninth bit.
- R3: While `rwu_o` is 1, a character whose ninth bit is 0 produces no `rx_valid` pulse, and `rx_data` and `rx_addr` keep their earlier values.
- R4: A character whose ninth bit is 1 clears `rwu_o` with no software action. `rwu_o` is already 0 a quarter of a bit time into that character's stop bit. The character is delivered with `rx_addr` equal to 1.
- R5: Idle line time of any length, before or between characters, leaves `rwu_o` at 1.
- R6: A one-cycle pulse on `rwu_set` makes `rwu_o` 1 from the next cycle on. When the pulse falls in the cycle where an address character would clear the flag, the set wins, `rwu_o` never drops, and that character is dropped.
- R7: A low pulse on `rx_in` shorter than half a bit time is not taken as a start bit. The next real character is received correctly.
- R8: Characters sent back to back with no idle time between them are each framed and delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit time |
| rx_in | input | 1 | Serial line, idle high |
| rwu_set | input | 1 | One-cycle strobe that puts the receiver to sleep |
| rwu_o | output | 1 | Sleep flag |
| rx_valid | output | 1 | One-cycle pulse for each delivered character |
| rx_data | output | 8 | Data byte of the last delivered character |
| rx_addr | output | 1 | Address flag of the last delivered character |

## Verification
The bench samples `rwu_o` in the first quarter of the stop bit of a waking character. A design that clears the flag at the stop sample, or after it, would still show the flag as 1 there, and it would lose the address character. The bench holds the set strobe across the whole address bit and watches every cycle. A design that lets the hardware clear win would show a one-cycle drop of the flag and might deliver the character. The bench also sends a short low glitch, long idle gaps while asleep, and back-to-back characters. A design that skips the half-bit start check would frame the glitch and shift every later character. A design that wakes on idle would deliver data characters it should drop.

// File: rtl/amw_pkg.sv
package amw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_ADDR  = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;
endpackage

// File: rtl/amw_sync.sv
module amw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= 1'b1;
                    else        stg[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= 1'b1;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/amw_framer.sv
module amw_framer
    import amw_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    output logic [DW:0]   word,
    output logic          addr_hit,
    output logic          frame_done
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW + 1);

    rx_state_e      st_q, st_d;
    logic [CW-1:0]  cnt_q;
    logic [BW-1:0]  bit_q;
    logic [DW:0]    sh_q;
    logic           samp, mid_start;

    assign samp      = tick && (cnt_q == CW'(OSR - 1));
    assign mid_start = tick && (cnt_q == CW'(OSR / 2 - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (tick && !rx) st_d = ST_START;
            ST_START: if (mid_start)   st_d = rx ? ST_IDLE : ST_DATA;
            ST_DATA:  if (samp && (bit_q == BW'(DW - 1))) st_d = ST_ADDR;
            ST_ADDR:  if (samp)        st_d = ST_STOP;
            ST_STOP:  if (samp)        st_d = ST_IDLE;
            default:                   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
        end else begin
            if (st_q == ST_IDLE) begin
                cnt_q <= '0;
                bit_q <= '0;
            end else if (st_q == ST_START) begin
                if (tick) cnt_q <= mid_start ? '0 : cnt_q + 1'b1;
            end else begin
                if (tick) cnt_q <= samp ? '0 : cnt_q + 1'b1;
            end
            if ((st_q == ST_DATA) && samp) bit_q <= bit_q + 1'b1;
            if (samp && ((st_q == ST_DATA) || (st_q == ST_ADDR)))
                sh_q <= {rx, sh_q[DW:1]};
        end
    end

    always_comb begin
        word       = sh_q;
        addr_hit   = (st_q == ST_ADDR) && samp && rx;
        frame_done = (st_q == ST_STOP) && samp;
    end

    // R2: every data bit has been taken before the address bit is sampled
    a_r2_all_bits_in: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR) |-> (bit_q == BW'(DW)));

    // R7: the data phase is only entered after a low start sample
    a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_DATA) && ($past(st_q) == ST_START)) |-> !$past(rx));
endmodule

// File: rtl/amw_wake.sv
module amw_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic rwu
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rwu <= 1'b0;
        else if (set_req) rwu <= 1'b1;
        else if (clr_req) rwu <= 1'b0;
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> rwu);

    a_r4_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !rwu);
endmodule

// File: rtl/amw_rx.sv
module amw_rx #(
    parameter int OSR       = 16,
    parameter int DW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_in,
    input  logic          rwu_set,
    output logic          rwu_o,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_addr
);
    logic          rx_s;
    logic [DW:0]   word;
    logic          addr_hit, frame_done;
    logic          rwu_q;

    amw_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
    );

    amw_framer #(.OSR(OSR), .DW(DW)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
        .word(word), .addr_hit(addr_hit), .frame_done(frame_done)
    );

    amw_wake u_wake (
        .clk(clk), .rst_n(rst_n), .set_req(rwu_set),
        .clr_req(addr_hit), .rwu(rwu_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_addr  <= 1'b0;
        end else begin
            rx_valid <= frame_done && !rwu_q;
            if (frame_done && !rwu_q) begin
                rx_data <= word[DW-1:0];
                rx_addr <= word[DW];
            end
        end
    end

    assign rwu_o = rwu_q;

    // R3: nothing is delivered from a character that ended while asleep
    a_r3_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !$past(rwu_q));

    // R3: the output register only moves with a delivery
    a_r3_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_addr)));

    // R2: delivery pulse is one clock wide
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: tb/sim_amw_rx.sv
`timescale 1ns/1ps
module sim_amw_rx;
    localparam int TDIV = 2;
    localparam int BITC = 16 * TDIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick;
    logic rx_in = 1'b1;
    logic rwu_set = 1'b0;
    logic rwu_o, rx_valid, rx_addr;
    logic [7:0] rx_data;

    int vectors = 0;
    int miscompares = 0;
    int vcnt = 0;
    logic [7:0] cap_d = '0;
    logic cap_a = 1'b0;
    bit done = 0;
    int tcnt = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    assign os_tick = (tcnt == 0);

    amw_rx u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .rwu_set(rwu_set), .rwu_o(rwu_o), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_addr(rx_addr)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcnt  <= vcnt + 1;
            cap_d <= rx_data;
            cap_a <= rx_addr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        rx_in = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        rx_in = b;
        repeat (BITC) @(negedge clk);
    endtask

    // sends one character; optional stop-bit probe of rwu and held set strobe
    task automatic send(input logic [7:0] d, input logic a,
                        input bit probe_wake, input bit hold_set,
                        output bit flag_dropped);
        flag_dropped = 0;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        rx_in = a;
        if (hold_set) rwu_set = 1'b1;
        for (int c = 0; c < BITC; c++) begin
            @(negedge clk);
            if (hold_set && !rwu_o) flag_dropped = 1;
        end
        rx_in = 1'b1;
        for (int c = 0; c < BITC; c++) begin
            @(negedge clk);
            if (hold_set && !rwu_o) flag_dropped = 1;
            if (probe_wake && c == BITC / 4 - 1)
                check(rwu_o == 1'b0, "R4 flag clear before stop sample", rwu_o, 0);
        end
        rwu_set = 1'b0;
    endtask

    task automatic sleep_now();
        @(negedge clk) rwu_set = 1'b1;
        @(negedge clk) rwu_set = 1'b0;
        check(rwu_o == 1'b1, "R6 set strobe", rwu_o, 1);
    endtask

    task automatic t_reset();
        check(rwu_o == 1'b0, "R1 rwu", rwu_o, 0);
        check(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
        check(rx_data == 8'h00, "R1 data", rx_data, 0);
        check(rx_addr == 1'b0, "R1 addr", rx_addr, 0);
    endtask

    task automatic t_awake();
        bit f;
        vcnt = 0;
        send(8'hA5, 1'b0, 0, 0, f); idle(8);
        check(vcnt == 1, "R2 one pulse", vcnt, 1);
        check(cap_d == 8'hA5, "R2 data", cap_d, 8'hA5);
        check(cap_a == 1'b0, "R2 addr flag 0", cap_a, 0);
        vcnt = 0;
        send(8'h3C, 1'b1, 0, 0, f); idle(8);
        check(vcnt == 1 && cap_d == 8'h3C, "R2 data", cap_d, 8'h3C);
        check(cap_a == 1'b1, "R2 addr flag 1", cap_a, 1);
    endtask

    task automatic t_drop_and_idle();
        bit f;
        sleep_now();
        idle(600);
        check(rwu_o == 1'b1, "R5 idle keeps sleep", rwu_o, 1);
        vcnt = 0;
        send(8'h5A, 1'b0, 0, 0, f); idle(700);
        send(8'hFF, 1'b0, 0, 0, f); idle(20);
        check(vcnt == 0, "R3 no pulse asleep", vcnt, 0);
        check(rx_data == 8'h3C, "R3 data held", rx_data, 8'h3C);
        check(rx_addr == 1'b1, "R3 addr held", rx_addr, 1);
        check(rwu_o == 1'b1, "R5 still asleep", rwu_o, 1);
    endtask

    task automatic t_wake();
        bit f;
        vcnt = 0;
        send(8'h81, 1'b1, 1, 0, f); idle(8);
        check(vcnt == 1, "R4 waking char delivered", vcnt, 1);
        check(cap_d == 8'h81 && cap_a == 1'b1, "R4 waking char content", {cap_a, cap_d}, 9'h181);
        check(rwu_o == 1'b0, "R4 awake after", rwu_o, 0);
        vcnt = 0;
        send(8'h42, 1'b0, 0, 0, f); idle(8);
        check(vcnt == 1 && cap_d == 8'h42, "R4 data after wake", cap_d, 8'h42);
    endtask

    task automatic t_set_wins();
        bit f;
        sleep_now();
        vcnt = 0;
        send(8'h99, 1'b1, 0, 1, f); idle(20);
        check(f == 0, "R6 set wins no drop", f, 0);
        check(rwu_o == 1'b1, "R6 set wins flag", rwu_o, 1);
        check(vcnt == 0, "R6 char dropped", vcnt, 0);
        check(rx_data == 8'h42, "R6 data held", rx_data, 8'h42);
        send(8'h07, 1'b1, 0, 0, f); idle(8);
        check(rwu_o == 1'b0 && cap_d == 8'h07, "R6 later wake", cap_d, 8'h07);
    endtask

    task automatic t_glitch();
        bit f;
        vcnt = 0;
        rx_in = 1'b0;
        repeat (BITC / 4) @(negedge clk);
        idle(3 * BITC);
        check(vcnt == 0, "R7 glitch no char", vcnt, 0);
        send(8'hC3, 1'b0, 0, 0, f); idle(8);
        check(vcnt == 1 && cap_d == 8'hC3, "R7 next char", cap_d, 8'hC3);
    endtask

    task automatic t_back_to_back();
        bit f;
        logic [7:0] got1;
        vcnt = 0;
        send(8'h11, 1'b0, 0, 0, f);
        got1 = cap_d;
        send(8'hEE, 1'b1, 0, 0, f);
        idle(8);
        check(vcnt == 2, "R8 two pulses", vcnt, 2);
        check(got1 == 8'h11, "R8 first", got1, 8'h11);
        check(cap_d == 8'hEE && cap_a == 1'b1, "R8 second", cap_d, 8'hEE);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(10);
        t_awake();
        t_drop_and_idle();
        t_wake();
        t_set_wins();
        t_glitch();
        t_back_to_back();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule